// File: doc/BRIEF.md
# Satellite Feed Channel Tone and Voltage Controller

This block holds the per-channel digital control for a dual-output feed supply for satellite receivers. It runs on the converter clock (nominally 220 kHz) and, for each channel, divides that clock by ten to make a 22 kHz square tone. It passes the tone to the output either continuously under a register bit or keyed by an external burst pin, which lets software send tone-burst signalling with no delay. It also forms a 2-bit output-level code from the level-select bit, the cable-loss compensation bit and an external pin that forces the high level. When a channel is switched on, the block runs a digital soft-start ramp and asserts a run enable for the converter and the linear stage.

A channel is active while its enable bit is high, supply power is good and the die is not in thermal shutdown. When a channel stops being active, its divider and ramp counter return to zero. The next time the channel is enabled, the ramp starts from its beginning and the tone starts in a known phase. The tone stays silent until the ramp has finished. All pins are plain control and status lines. There is no data stream, so no handshake is needed.

Top module: `lnb_chan_ctl`

## Requirements
- R1: While a channel's tone is passed, tone_wave repeats every TONE_DIV (10) clocks, high for 5 and low for 5. Counting n as the rising clock edges at which the channel has been active since it was last enabled, the wave is high exactly when (n mod 10) < 5.
- R2: With tone_on high, tone_gate is high whenever the channel is active and soft-start has finished, whatever the level of burst_in.
- R3: With tone_on low and the channel active with soft-start finished, tone_gate follows burst_in in the same cycle, with no register in between.
- R4: vcode holds two bits per channel. Bit 1 selects the high level and bit 0 adds the one-step compensation, so 00=13 V, 01=14 V, 10=18 V and 11=19 V. Bit 1 equals reg_vsel and bit 0 equals reg_llc.
- R5: force_hi high sets vcode bit 1 whatever reg_vsel is, and bit 0 still follows reg_llc.
- R6: With reg_en low, run_en is low from the next clock edge, ss_count returns to 0 at that edge, and tone_gate and tone_wave are low at once.
- R7: While a channel is active, ss_count rises by one at each clock edge from 0 and holds at SS_CYCLES (512). Soft-start is finished when ss_count equals SS_CYCLES.
- R8: tone_gate and tone_wave stay low while ss_count is below SS_CYCLES, even with tone_on or burst_in high.
- R9: Thermal shutdown high or power-good low makes every channel inactive, with the same effect as R6.
- R10: The channels are independent. Enabling, keying or changing the level of one channel does not alter the outputs of another.
- R11: When a channel is enabled again after being inactive, soft-start restarts from 0 and the tone phase of R1 restarts with n counted from the new enable.
- R12: During the asynchronous reset (rst_n low), run_en, ss_count, tone_gate and tone_wave are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Converter clock (nominally 220 kHz) |
| rst_n | input | 1 | Asynchronous active-low reset |
| pwr_ok | input | 1 | Supply power good; low disables all channels |
| therm_sd | input | 1 | Thermal shutdown; high disables all channels |
| reg_en | input | NUM_CH | Per-channel enable bit |
| reg_vsel | input | NUM_CH | Per-channel high-level select bit |
| reg_llc | input | NUM_CH | Per-channel cable-loss compensation bit (+1 step) |
| reg_tone_on | input | NUM_CH | Per-channel continuous-tone bit |
| burst_in | input | NUM_CH | Per-channel external tone keying pin |
| force_hi | input | NUM_CH | Per-channel external pin forcing the high level |
| run_en | output | NUM_CH | Converter and regulator run enable, registered |
| tone_gate | output | NUM_CH | Tone is being passed on this channel |
| tone_wave | output | NUM_CH | Gated tone waveform |
| vcode | output | 2*NUM_CH | Output-level code, 2 bits per channel |
| ss_count | output | NUM_CH*clog2(SS_CYCLES+1) | Soft-start ramp count per channel |

## Verification
The bench tracks the tone phase cycle by cycle from the moment a channel is enabled. A divider that is not cleared on disable, or that counts from the wrong origin, shows up as a shifted wave after a re-enable. It checks the last ramp cycle (511) and the first finished cycle (512), where an off-by-one in the soft-start compare would let the tone out one clock early or hold it one clock too long. Burst keying is checked in the same cycle as the pin changes, which catches a design that registers the pin or lets it through while the continuous bit is set. The force pin is swept against every combination of select and compensation, and thermal shutdown and power loss are applied with both channels running, to catch a design that clears only one channel.

// File: rtl/lnb_ctl_pkg.sv
package lnb_ctl_pkg;

  typedef enum logic [1:0] {
    VOUT_BASE      = 2'b00,
    VOUT_BASE_COMP = 2'b01,
    VOUT_HIGH      = 2'b10,
    VOUT_HIGH_COMP = 2'b11
  } vout_code_e;

  function automatic vout_code_e level_code(input logic high_lvl, input logic comp);
    vout_code_e c;
    unique case ({high_lvl, comp})
      2'b00:   c = VOUT_BASE;
      2'b01:   c = VOUT_BASE_COMP;
      2'b10:   c = VOUT_HIGH;
      default: c = VOUT_HIGH_COMP;
    endcase
    return c;
  endfunction

endpackage

// File: rtl/lnb_tone_div.sv
module lnb_tone_div #(
  parameter int TONE_DIV = 10
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic wave
);
  localparam int DW   = (TONE_DIV > 2) ? $clog2(TONE_DIV) : 1;
  localparam int HALF = TONE_DIV / 2;
  localparam logic [DW-1:0] LAST = DW'(TONE_DIV - 1);

  logic [DW-1:0] phase;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)             phase <= '0;
    else if (!run)          phase <= '0;
    else if (phase == LAST) phase <= '0;
    else                    phase <= phase + 1'b1;
  end

  assign wave = (phase < DW'(HALF));
endmodule

// File: rtl/lnb_softstart.sv
module lnb_softstart #(
  parameter int SS_CYCLES = 512
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic [$clog2(SS_CYCLES+1)-1:0] ramp,
  output logic done
);
  localparam int SW = $clog2(SS_CYCLES + 1);
  localparam logic [SW-1:0] FULL = SW'(SS_CYCLES);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     ramp <= '0;
    else if (!run)  ramp <= '0;
    else if (!done) ramp <= ramp + 1'b1;
  end

  assign done = (ramp == FULL);
endmodule

// File: rtl/lnb_vsel_enc.sv
module lnb_vsel_enc (
  input  logic       vsel,
  input  logic       llc,
  input  logic       force_hi,
  output logic [1:0] code
);
  import lnb_ctl_pkg::*;

  vout_code_e sel;

  always_comb sel = level_code(vsel | force_hi, llc);

  assign code = sel;
endmodule

// File: rtl/lnb_chan.sv
module lnb_chan #(
  parameter int TONE_DIV  = 10,
  parameter int SS_CYCLES = 512
) (
  input  logic clk,
  input  logic rst_n,
  input  logic active,
  input  logic tone_on,
  input  logic burst,
  input  logic vsel,
  input  logic llc,
  input  logic force_hi,
  output logic run_en,
  output logic tone_gate,
  output logic tone_wave,
  output logic [1:0] vcode,
  output logic [$clog2(SS_CYCLES+1)-1:0] ramp
);
  logic ss_done;
  logic raw_wave;

  lnb_softstart #(.SS_CYCLES(SS_CYCLES)) u_ss (
    .clk   (clk),
    .rst_n (rst_n),
    .run   (active),
    .ramp  (ramp),
    .done  (ss_done)
  );

  lnb_tone_div #(.TONE_DIV(TONE_DIV)) u_div (
    .clk   (clk),
    .rst_n (rst_n),
    .run   (active),
    .wave  (raw_wave)
  );

  lnb_vsel_enc u_enc (
    .vsel     (vsel),
    .llc      (llc),
    .force_hi (force_hi),
    .code     (vcode)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) run_en <= 1'b0;
    else        run_en <= active;
  end

  assign tone_gate = active & ss_done & (tone_on | burst);
  assign tone_wave = tone_gate & raw_wave;
endmodule

// File: rtl/lnb_chan_ctl.sv
module lnb_chan_ctl #(
  parameter int NUM_CH    = 2,
  parameter int TONE_DIV  = 10,
  parameter int SS_CYCLES = 512
) (
  input  logic                                    clk,
  input  logic                                    rst_n,
  input  logic                                    pwr_ok,
  input  logic                                    therm_sd,
  input  logic [NUM_CH-1:0]                       reg_en,
  input  logic [NUM_CH-1:0]                       reg_vsel,
  input  logic [NUM_CH-1:0]                       reg_llc,
  input  logic [NUM_CH-1:0]                       reg_tone_on,
  input  logic [NUM_CH-1:0]                       burst_in,
  input  logic [NUM_CH-1:0]                       force_hi,
  output logic [NUM_CH-1:0]                       run_en,
  output logic [NUM_CH-1:0]                       tone_gate,
  output logic [NUM_CH-1:0]                       tone_wave,
  output logic [2*NUM_CH-1:0]                     vcode,
  output logic [NUM_CH*$clog2(SS_CYCLES+1)-1:0]   ss_count
);
  localparam int SW = $clog2(SS_CYCLES + 1);

  logic chip_ok;
  logic [NUM_CH-1:0] active;

  assign chip_ok = pwr_ok & ~therm_sd;

  for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
    assign active[g] = chip_ok & reg_en[g];

    lnb_chan #(.TONE_DIV(TONE_DIV), .SS_CYCLES(SS_CYCLES)) u_chan (
      .clk       (clk),
      .rst_n     (rst_n),
      .active    (active[g]),
      .tone_on   (reg_tone_on[g]),
      .burst     (burst_in[g]),
      .vsel      (reg_vsel[g]),
      .llc       (reg_llc[g]),
      .force_hi  (force_hi[g]),
      .run_en    (run_en[g]),
      .tone_gate (tone_gate[g]),
      .tone_wave (tone_wave[g]),
      .vcode     (vcode[2*g +: 2]),
      .ramp      (ss_count[g*SW +: SW])
    );
  end
endmodule

// File: rtl/lnb_chan_ctl_chk.sv
module lnb_chan_ctl_chk #(
  parameter int NUM_CH    = 2,
  parameter int SS_CYCLES = 512
) (
  input logic                                  clk,
  input logic                                  rst_n,
  input logic                                  pwr_ok,
  input logic                                  therm_sd,
  input logic [NUM_CH-1:0]                     reg_en,
  input logic [NUM_CH-1:0]                     reg_vsel,
  input logic [NUM_CH-1:0]                     reg_llc,
  input logic [NUM_CH-1:0]                     reg_tone_on,
  input logic [NUM_CH-1:0]                     burst_in,
  input logic [NUM_CH-1:0]                     force_hi,
  input logic [NUM_CH-1:0]                     run_en,
  input logic [NUM_CH-1:0]                     tone_gate,
  input logic [NUM_CH-1:0]                     tone_wave,
  input logic [2*NUM_CH-1:0]                   vcode,
  input logic [NUM_CH*$clog2(SS_CYCLES+1)-1:0] ss_count
);
  localparam int SW = $clog2(SS_CYCLES + 1);
  localparam logic [SW-1:0] FULL = SW'(SS_CYCLES);

  for (genvar i = 0; i < NUM_CH; i++) begin : g_chk
    logic live;
    logic ready;
    assign live  = pwr_ok && !therm_sd && reg_en[i];
    assign ready = live && (ss_count[i*SW +: SW] == FULL);

    assert_cont_tone_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (ready && reg_tone_on[i]) |-> tone_gate[i]);

    assert_burst_follow_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (ready && !reg_tone_on[i]) |-> (tone_gate[i] == burst_in[i]));

    assert_force_high_R5: assert property (@(posedge clk) disable iff (!rst_n)
      force_hi[i] |-> vcode[2*i+1]);

    assert_base_level_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (!force_hi[i] && !reg_vsel[i]) |-> !vcode[2*i+1]);

    assert_comp_bit_R4: assert property (@(posedge clk) disable iff (!rst_n)
      reg_llc[i] |-> vcode[2*i]);

    assert_disable_R6: assert property (@(posedge clk) disable iff (!rst_n)
      !reg_en[i] |=> (!run_en[i] && ss_count[i*SW +: SW] == '0));

    assert_ramp_step_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (live && ss_count[i*SW +: SW] != FULL) |=>
        (ss_count[i*SW +: SW] == $past(ss_count[i*SW +: SW]) + SW'(1)));

    assert_quiet_ramp_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (ss_count[i*SW +: SW] != FULL) |-> !tone_gate[i]);

    assert_wave_gated_R8: assert property (@(posedge clk) disable iff (!rst_n)
      tone_wave[i] |-> tone_gate[i]);

    assert_chip_off_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (!pwr_ok || therm_sd) |=> (!run_en[i] && ss_count[i*SW +: SW] == '0));
  end
endmodule

bind lnb_chan_ctl lnb_chan_ctl_chk #(.NUM_CH(NUM_CH), .SS_CYCLES(SS_CYCLES)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .pwr_ok      (pwr_ok),
  .therm_sd    (therm_sd),
  .reg_en      (reg_en),
  .reg_vsel    (reg_vsel),
  .reg_llc     (reg_llc),
  .reg_tone_on (reg_tone_on),
  .burst_in    (burst_in),
  .force_hi    (force_hi),
  .run_en      (run_en),
  .tone_gate   (tone_gate),
  .tone_wave   (tone_wave),
  .vcode       (vcode),
  .ss_count    (ss_count)
);

// File: tb/tb_lnb_chan_ctl.sv
module tb_lnb_chan_ctl;
  localparam int NUM_CH = 2;
  localparam int TONE_DIV = 10;
  localparam int SS_CYCLES = 512;
  localparam int SW = $clog2(SS_CYCLES + 1);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic pwr_ok = 1'b1;
  logic therm_sd = 1'b0;
  logic [NUM_CH-1:0] reg_en = '0, reg_vsel = '0, reg_llc = '0;
  logic [NUM_CH-1:0] reg_tone_on = '0, burst_in = '0, force_hi = '0;
  logic [NUM_CH-1:0] run_en, tone_gate, tone_wave;
  logic [2*NUM_CH-1:0] vcode;
  logic [NUM_CH*SW-1:0] ss_count;

  int checks = 0;
  int errors = 0;
  int k0 = 0;
  int k1 = 0;

  always #4 clk = ~clk;

  lnb_chan_ctl #(.NUM_CH(NUM_CH), .TONE_DIV(TONE_DIV), .SS_CYCLES(SS_CYCLES)) dut (
    .clk(clk), .rst_n(rst_n), .pwr_ok(pwr_ok), .therm_sd(therm_sd),
    .reg_en(reg_en), .reg_vsel(reg_vsel), .reg_llc(reg_llc),
    .reg_tone_on(reg_tone_on), .burst_in(burst_in), .force_hi(force_hi),
    .run_en(run_en), .tone_gate(tone_gate), .tone_wave(tone_wave),
    .vcode(vcode), .ss_count(ss_count)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
    k0++;
    k1++;
  endtask

  function automatic int ramp(input int ch);
    return int'(ss_count[ch*SW +: SW]);
  endfunction

  function automatic int phase_hi(input int n);
    return ((n % TONE_DIV) < TONE_DIV / 2) ? 1 : 0;
  endfunction

  task automatic wait_ramp0();
    while (k0 < SS_CYCLES) tick();
  endtask

  task automatic t_reset();
    #1;
    chk("R12 run_en", int'(run_en), 0);
    chk("R12 ss_count", int'(ss_count), 0);
    chk("R12 tone_gate", int'(tone_gate), 0);
    chk("R12 tone_wave", int'(tone_wave), 0);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic t_vcode();
    for (int c = 0; c < 16; c++) begin
      @(negedge clk);
      reg_vsel[0] = c[0]; reg_llc[0] = c[1]; force_hi[0] = c[2]; reg_llc[1] = c[3];
      #1;
      chk("R4/R5 ch0 vcode", int'(vcode[1:0]), ((c[0] | c[2]) ? 2 : 0) + (c[1] ? 1 : 0));
      chk("R10 ch1 vcode", int'(vcode[3:2]), c[3] ? 1 : 0);
    end
    @(negedge clk);
    reg_vsel = '0; reg_llc = '0; force_hi = '0;
  endtask

  task automatic t_softstart_tone();
    @(negedge clk);
    reg_en[0] = 1'b1; reg_tone_on[0] = 1'b1; burst_in[0] = 1'b0;
    k0 = 0;
    tick();
    chk("R6 run_en rises", int'(run_en[0]), 1);
    chk("R10 ch1 idle", int'(run_en[1]), 0);
    while (k0 < SS_CYCLES + 30) begin
      chk("R7 ramp", ramp(0), (k0 < SS_CYCLES) ? k0 : SS_CYCLES);
      if (k0 < SS_CYCLES) begin
        chk("R8 gate quiet", int'(tone_gate[0]), 0);
        chk("R8 wave quiet", int'(tone_wave[0]), 0);
      end else begin
        chk("R2 gate on", int'(tone_gate[0]), 1);
        chk("R1 wave phase", int'(tone_wave[0]), phase_hi(k0));
      end
      chk("R10 ch1 ramp", ramp(1), 0);
      tick();
    end
  endtask

  task automatic t_burst();
    @(negedge clk);
    k0++;
    reg_tone_on[0] = 1'b0; burst_in[0] = 1'b0;
    #1;
    chk("R3 gate off", int'(tone_gate[0]), 0);
    for (int j = 0; j < 24; j++) begin
      @(negedge clk);
      k0++;
      burst_in[0] = (j % 3) != 0;
      #1;
      chk("R3 gate follows pin", int'(tone_gate[0]), int'(burst_in[0]));
      chk("R3 wave keyed", int'(tone_wave[0]), burst_in[0] ? phase_hi(k0) : 0);
    end
    @(negedge clk);
    k0++;
    reg_tone_on[0] = 1'b1; burst_in[0] = 1'b0;
    #1;
    chk("R2 pin ignored", int'(tone_gate[0]), 1);
  endtask

  task automatic t_disable_realign();
    @(negedge clk);
    reg_en[0] = 1'b0;
    #1;
    chk("R6 gate drops", int'(tone_gate[0]), 0);
    chk("R6 wave drops", int'(tone_wave[0]), 0);
    tick();
    chk("R6 run_en low", int'(run_en[0]), 0);
    chk("R6 ramp cleared", ramp(0), 0);
    repeat (7) tick();
    chk("R6 stays off", ramp(0), 0);
    reg_en[0] = 1'b1;
    k0 = 0;
    tick();
    chk("R11 ramp restarts", ramp(0), 1);
    wait_ramp0();
    chk("R11 ramp full", ramp(0), SS_CYCLES);
    repeat (20) begin
      chk("R11 phase realigned", int'(tone_wave[0]), phase_hi(k0));
      tick();
    end
  endtask

  task automatic t_chip_off(input bit use_therm);
    string tag;
    tag = use_therm ? "R9 thermal" : "R9 power";
    @(negedge clk);
    reg_en = '1; reg_tone_on = '1;
    k1 = 0;
    if (ramp(0) == 0) k0 = 0;
    while (k1 < SS_CYCLES) tick();
    chk({tag, " ch1 running"}, int'(tone_gate[1]), 1);
    chk({tag, " ch0 running"}, int'(tone_gate[0]), 1);
    if (use_therm) therm_sd = 1'b1; else pwr_ok = 1'b0;
    #1;
    chk({tag, " gates drop"}, int'(tone_gate), 0);
    tick();
    chk({tag, " run_en low"}, int'(run_en), 0);
    chk({tag, " ramps cleared"}, int'(ss_count), 0);
    therm_sd = 1'b0; pwr_ok = 1'b1;
    k0 = 0;
    tick();
    chk({tag, " restart ch0"}, ramp(0), 1);
    chk({tag, " restart ch1"}, ramp(1), 1);
  endtask

  initial begin
    t_reset();
    t_vcode();
    t_softstart_tone();
    t_burst();
    t_disable_realign();
    t_chip_off(1'b1);
    t_chip_off(1'b0);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule